// File: doc/BRIEF.md
# Packed-Multiply Pixel Index Hash

This block turns a 32-bit RGBA pixel into a 6-bit slot number for a small cache of recently seen pixels inside an image compressor. The slot is the channel sum weighted 3, 5, 7 and 11 for red, green, blue and alpha, reduced modulo 64. Each channel is one byte of the pixel word.

It does not use four separate multipliers. The pixel bytes are spread into a 64-bit operand, and one wrapping 64x64 multiply by a packed constant follows. The coefficients in that constant are stored in the reverse of the channel order. Because of this ordering, every wanted partial product has a total shift of 56 bits and lands in the top byte of the product. The unwanted cross terms either carry past bit 63 and are lost, or stay in lower bytes that are never read. The low six bits of the top byte form the index.

The block is a two-stage pipeline with a valid/ready input. A single downstream ready stalls both stages together.

Top module: `pix_hash_idx`

## Requirements
- R1: `out_index` equals (r*3 + g*5 + b*7 + a*11) mod 64. Here r is `in_pixel[7:0]`, g is `in_pixel[15:8]`, b is `in_pixel[23:16]` and a is `in_pixel[31:24]`.
- R2: A pixel of 0x00000000 yields index 0.
- R3: A pixel of 0xFFFFFFFF yields index 38.
- R4: A pixel accepted at a clock edge appears with `out_valid` high after the second following edge, provided `out_ready` is high at that second edge.
- R5: While `out_ready` is low, `in_ready` is low, and a valid output keeps both `out_valid` and `out_index` unchanged.
- R6: No accepted pixel is lost or duplicated. Results leave in the order their pixels were accepted.
- R7: While `rst_n` is low at a clock edge, `out_valid` is low after that edge.
- R8: The pixel word 0x78563412 (r=0x12, g=0x34, b=0x56, a=0x78) yields index 60.
- R9: A cycle that advances the pipeline with `in_valid` low produces no output two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel word is offered |
| in_ready | output | 1 | Block takes the offered pixel at this edge |
| in_pixel | input | 32 | RGBA word, red in the low byte |
| out_valid | output | 1 | `out_index` holds a result |
| out_ready | input | 1 | Downstream takes the result; low stalls the pipeline |
| out_index | output | 6 | Cache slot index |

## Verification
The hardest case to reach is a stall that starts while both stages hold different pixels and a third pixel is waiting at the input. In that case ordering and hold behaviour matter together. The stimulus reaches it in two ways. A directed sequence keeps `in_valid` high and drops `out_ready` for several cycles. A long random phase toggles `in_valid` and `out_ready` independently, so that bubbles, back-to-back pixels and stalls mix in every combination. A behavioural queue model checks each clock against the weighted-sum formula.

// File: rtl/pix_hash_pkg.sv
// Package: shared constants for the packed-multiply pixel hash.
// Assumes four byte-wide channels; the weights are packed in reverse
// channel order so that all wanted products meet in the top byte.
package pix_hash_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int IDX_W   = 6;
    localparam int PIX_W   = LANE_W * LANES;
    localparam int WIDE_W  = 2 * PIX_W;
    // Keeps red at bit 0, blue at 16, green at 40, alpha at 56.
    localparam logic [WIDE_W-1:0] SPREAD_MASK = 64'hFF00FF0000FF00FF;
    // Weights 11 @0, 5 @16, 7 @40, 3 @56 (reverse of channel order).
    localparam logic [WIDE_W-1:0] WEIGHT_PACK = 64'h030007000005000B;
endpackage

// File: rtl/pix_spread.sv
// Module: pix_spread
// Copies the pixel word into every PIX_W slice of a wide word, then keeps
// only the bytes selected by MASK. Assumes WIDE_W is a multiple of PIX_W.
module pix_spread #(
    parameter int PIX_W  = 32,
    parameter int WIDE_W = 64,
    parameter logic [WIDE_W-1:0] MASK = '1
) (
    input  logic [PIX_W-1:0]  pix,
    output logic [WIDE_W-1:0] spread
);
    localparam int REPS = WIDE_W / PIX_W;

    logic [WIDE_W-1:0] dup;

    // Replicate the pixel into each slice of the wide word.
    for (genvar c = 0; c < REPS; c++) begin : g_dup
        assign dup[c*PIX_W +: PIX_W] = pix;
    end

    // Mask away the bytes that must not enter the multiply.
    assign spread = dup & MASK;
endmodule

// File: rtl/pix_pack_mul.sv
// Module: pix_pack_mul
// Wrapping WIDE_W x WIDE_W multiply by the constant COEF. Returns only the
// top LANE_W bits of the low WIDE_W product bits. STYLE 0 uses one
// multiply; STYLE 1 sums one shifted term per coefficient byte.
// Assumes the wanted products sit in the top lane.
module pix_pack_mul #(
    parameter int WIDE_W = 64,
    parameter int LANE_W = 8,
    parameter int STYLE  = 0,
    parameter logic [WIDE_W-1:0] COEF = '0
) (
    input  logic [WIDE_W-1:0] opnd,
    output logic [LANE_W-1:0] top
);
    localparam int TOP_LSB = WIDE_W - LANE_W;
    localparam int NBYTES  = WIDE_W / LANE_W;

    if (STYLE == 0) begin : g_direct
        // One multiply; shift the top lane down and truncate.
        assign top = LANE_W'((opnd * COEF) >> TOP_LSB);
    end else begin : g_bytewise
        logic [WIDE_W-1:0] terms [NBYTES];
        logic [WIDE_W-1:0] acc;

        for (genvar k = 0; k < NBYTES; k++) begin : g_term
            localparam logic [WIDE_W-1:0] CB =
                {{(WIDE_W-LANE_W){1'b0}}, COEF[k*LANE_W +: LANE_W]};
            // One partial product per coefficient byte, at its own offset.
            assign terms[k] = (opnd * CB) << (k * LANE_W);
        end

        // Sum the partial products modulo 2**WIDE_W.
        always_comb begin
            acc = '0;
            for (int k = 0; k < NBYTES; k++) acc = acc + terms[k];
        end

        // Keep only the top lane of the sum.
        assign top = LANE_W'(acc >> TOP_LSB);
    end
endmodule

// File: rtl/pix_pipe_reg.sv
// Module: pix_pipe_reg
// One pipeline register holding a valid flag and a payload. It loads when
// en is high and holds otherwise. Synchronous active-low reset clears it.
module pix_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    // Load on enable, clear on reset, otherwise keep the contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (en) begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end
endmodule

// File: rtl/pix_hash_idx.sv
// Module: pix_hash_idx (top)
// Two-stage pixel cache index hash. Stage 1 spreads the pixel and runs the
// packed multiply, registering the top product byte. Stage 2 keeps the low
// IDX_W bits. Both stages advance only while out_ready is high.
// Assumes four channels and IDX_W <= LANE_W.
module pix_hash_idx
    import pix_hash_pkg::*;
#(
    parameter int MUL_STYLE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_index
);
    logic              advance;
    logic [WIDE_W-1:0] spread;
    logic [LANE_W-1:0] prod_top;
    logic              s1_valid;
    logic [LANE_W-1:0] s1_byte;
    logic [IDX_W-1:0]  s1_idx;

    // Single stall: the whole pipeline moves only when downstream takes.
    assign advance  = out_ready;
    assign in_ready = advance;

    pix_spread #(.PIX_W(PIX_W), .WIDE_W(WIDE_W), .MASK(SPREAD_MASK)) u_spread (
        .pix    (in_pixel),
        .spread (spread)
    );

    pix_pack_mul #(.WIDE_W(WIDE_W), .LANE_W(LANE_W), .STYLE(MUL_STYLE),
                   .COEF(WEIGHT_PACK)) u_mul (
        .opnd (spread),
        .top  (prod_top)
    );

    pix_pipe_reg #(.W(LANE_W)) u_stage1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (advance),
        .d_valid (in_valid),
        .d_data  (prod_top),
        .q_valid (s1_valid),
        .q_data  (s1_byte)
    );

    // The index is the top product byte reduced modulo 2**IDX_W.
    assign s1_idx = IDX_W'(s1_byte);

    pix_pipe_reg #(.W(IDX_W)) u_stage2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (advance),
        .d_valid (s1_valid),
        .d_data  (s1_idx),
        .q_valid (out_valid),
        .q_data  (out_index)
    );
endmodule

// File: rtl/pix_hash_idx_chk.sv
// Module: pix_hash_idx_chk
// Port-level assertions for pix_hash_idx, attached with bind.
module pix_hash_idx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [31:0] in_pixel,
    input logic       out_valid,
    input logic       out_ready,
    input logic [5:0] out_index
);
    function automatic logic [5:0] wsum(input logic [31:0] p);
        int s;
        s = 3 * int'(p[7:0]) + 5 * int'(p[15:8]) + 7 * int'(p[23:16]) + 11 * int'(p[31:24]);
        return 6'(s % 64);
    endfunction

    // R7
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

    // R1
    index_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && $past(rst_n && in_valid && in_ready)) |=>
        (out_valid && out_index == wsum($past(in_pixel, 2))));

    // R6
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_valid) && $past(rst_n)) |-> $past(out_ready));

    // R9
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && $past(rst_n && in_ready && !in_valid)) |=> !out_valid);
endmodule

bind pix_hash_idx pix_hash_idx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pixel  (in_pixel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_index (out_index)
);

// File: tb/sim_pix_hash_idx.sv
`timescale 1ns/100ps
module sim_pix_hash_idx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [5:0]  out_index;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Behavioural model: two slots advanced on each enabled edge.
    bit       mv1 = 0, mv2 = 0;
    int       md1 = 0, md2 = 0;
    int       n_in = 0, n_out = 0;

    always #2.5 clk = ~clk;

    pix_hash_idx u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_index(out_index)
    );

    function automatic int ref_idx(input logic [31:0] p);
        return (3 * int'(p[7:0]) + 5 * int'(p[15:8]) + 7 * int'(p[23:16]) + 11 * int'(p[31:24])) % 64;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at the active edge; reads only bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            mv1 = 0; mv2 = 0;
        end else if (out_ready) begin
            mv2 = mv1; md2 = md1;
            mv1 = in_valid; md1 = ref_idx(in_pixel);
        end
    end

    // Compare with the model away from the edge, every cycle.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(out_valid == mv2, "R4 out_valid timing", int'(out_valid), int'(mv2));
            if (mv2 && out_valid)
                chk(int'(out_index) == md2, "R1 index value", int'(out_index), md2);
            if (!out_ready)
                chk(in_ready == 1'b0, "R5 in_ready during stall", int'(in_ready), 0);
            if (in_valid && in_ready) n_in++;
            if (out_valid && out_ready) n_out++;
        end
    end

    // Offer one pixel with no stall, check it two edges later.
    task automatic one_pixel(input logic [31:0] p, input int exp, input string req);
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1; in_pixel = p;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b1, req, int'(out_valid), 1);
        chk(int'(out_index) == exp, req, int'(out_index), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R7 reset state", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        one_pixel(32'h0000_0000, 0,  "R2 all-zero pixel");
        one_pixel(32'hFFFF_FFFF, 38, "R3 all-ones pixel");
        one_pixel(32'h7856_3412, 60, "R8 worked example");
        one_pixel(32'h0000_0001, 3,  "R1 red lane alone");
        one_pixel(32'h0100_0000, 11, "R1 alpha lane alone");

        // R9: bubbles produce no output.
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R9 bubble gives no output", int'(out_valid), 0);

        // R5: stall with both stages full and a third pixel waiting.
        @(negedge clk);
        in_valid = 1'b1; in_pixel = 32'h0102_0304;
        @(negedge clk);
        in_pixel = 32'hA0B0_C0D0;
        @(negedge clk);
        in_pixel = 32'h5555_AAAA; out_ready = 1'b0;
        #1;
        begin
            int held = ref_idx(32'h0102_0304);
            repeat (5) begin
                @(negedge clk);
                #1;
                chk(out_valid && int'(out_index) == held, "R5 hold during stall",
                    int'(out_index), held);
            end
        end
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b0;
        repeat (4) @(negedge clk);

        // Random mix of pixels, bubbles and stalls.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            in_valid  = ($urandom_range(0, 3) != 0);
            out_ready = ($urandom_range(0, 3) != 0);
            in_pixel  = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (5) @(negedge clk);
        #2;
        chk(n_in == n_out, "R6 accepted equals delivered", n_out, n_in);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule